// File: doc/BRIEF.md
# Token-Ring Mutex Acquisition Unit

This block arbitrates a set of hardware mutexes among several requesting nodes without a central lock register. A free-running turn counter names one node per cycle as the token holder, the node number being the cycle count since reset taken modulo the node count. Each node holds its own copy of the mutex status table. Only the token holder may change a mutex. It changes its own copy at once and sends the change down a fixed-latency broadcast path to every other copy.

While a broadcast is in flight, a shared busy line is high. No node may commit while that line is high, because its local copy may be stale. A node that wants a mutex keeps its request high. On each of its turns it checks its local copy and the busy line, and commits only when the mutex is free and no broadcast is in flight. Releases use the same turn-and-broadcast path. Every commit, acquire or release, is reported by a one-cycle grant pulse. The caller drops its request in the cycle it sees that pulse.

Top module: `token_mutex_ring`

## Requirements
- R1: The node holding the turn is the number of clock cycles since reset, modulo NODES (node 0 in the first cycle after reset). A grant to node n appears only in the cycle after a clock edge at which node n held the turn.
- R2: During and right after reset, every table bit is 0 (free), busy_o is low and grant_o is all zero.
- R3: An acquire (req_i[n]=1, rel_i[n]=0, index in idx_i[n*IDXW +: IDXW]) is committed on node n's turn when its local bit is 0 and busy_o is low. grant_o[n] is then high for exactly one cycle, and table_o[n*MUTEXES+m] reads 1 in that same cycle.
- R4: An acquire of a mutex whose local bit is 1 is not granted. The request stays pending and is retried on every later turn of that node, and is granted once the bit has become 0.
- R5: A release (rel_i[n]=1) commits on node n's turn while busy_o is low. It pulses grant_o[n] and makes table_o[n*MUTEXES+m] read 0 in the grant cycle.
- R6: busy_o rises in the cycle of each grant pulse and stays high for exactly PROP_CYCLES consecutive cycles.
- R7: The tables of the other nodes take the new value in the cycle busy_o falls. Whenever busy_o is low, all node tables are identical.
- R8: No node commits while busy_o is high. Two grants are therefore at least PROP_CYCLES cycles apart.
- R9: A mutex is never granted to two nodes for acquire. Simultaneous acquires of one free mutex by two nodes yield exactly one grant, and at most one grant bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NODES | Per-node request, held until the grant pulse |
| rel_i | input | NODES | Per-node operation: 1 release, 0 acquire |
| idx_i | input | NODES*IDXW | Per-node mutex index, node n at bits n*IDXW +: IDXW |
| grant_o | output | NODES | One-cycle commit pulse per node |
| busy_o | output | 1 | High while a table update is propagating |
| table_o | output | NODES*MUTEXES | All table copies, node n mutex m at bit n*MUTEXES+m |

## Verification
A corrupted table copy shows up the moment busy_o is low: table_o rows disagree. It can also surface later as a wrong grant, or a missing one, on that node's next turn, which is at most NODES cycles away. A wrong turn counter shows up as a grant whose cycle does not match the count since reset modulo NODES. A broken propagation delay shows up as a busy run whose length differs from PROP_CYCLES, or as a grant issued inside a busy run. Contention scenarios check exclusion directly, through grant counts and through the table bits seen after each broadcast settles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Width of the index and source fields carried on the broadcast path.
    localparam int TMR_FW = 8;

    typedef enum logic { OP_ACQ = 1'b0, OP_REL = 1'b1 } tmr_op_e;

    typedef struct packed {
        logic              valid;
        logic              set;
        logic [TMR_FW-1:0] src;
        logic [TMR_FW-1:0] idx;
    } tmr_upd_t;

    function automatic int tmr_idxw(input int count);
        return (count <= 1) ? 1 : $clog2(count);
    endfunction

endpackage

// File: rtl/tmr_turn_counter.sv
module tmr_turn_counter
    import tmr_pkg::*;
#(
    parameter int NODES = 4,
    localparam int TW = tmr_idxw(NODES)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [TW-1:0] turn,
    output logic [NODES-1:0] turn_1h
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == TW'(NODES - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign turn = cnt_q;

    always_comb begin
        turn_1h = '0;
        turn_1h[cnt_q] = 1'b1;
    end
endmodule

// File: rtl/tmr_bcast_pipe.sv
module tmr_bcast_pipe
    import tmr_pkg::*;
#(
    parameter int PROP_CYCLES = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  tmr_upd_t upd_in,
    output tmr_upd_t upd_out,
    output logic     in_flight
);
    tmr_upd_t           stage_q [PROP_CYCLES];
    logic [PROP_CYCLES-1:0] vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= upd_in;
        end
    end

    genvar k;
    generate
        for (k = 1; k < PROP_CYCLES; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[k] <= '0;
                end else begin
                    stage_q[k] <= stage_q[k-1];
                end
            end
        end
        for (k = 0; k < PROP_CYCLES; k++) begin : g_vld
            assign vld[k] = stage_q[k].valid;
        end
    endgenerate

    assign upd_out   = stage_q[PROP_CYCLES-1];
    assign in_flight = |vld;
endmodule

// File: rtl/tmr_node.sv
module tmr_node
    import tmr_pkg::*;
#(
    parameter int MUTEXES = 8,
    parameter int ID      = 0,
    localparam int IDXW   = tmr_idxw(MUTEXES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               my_turn,
    input  logic               busy,
    input  logic               req,
    input  tmr_op_e            op,
    input  logic [IDXW-1:0]    idx,
    input  tmr_upd_t           bcast,
    output logic               commit,
    output tmr_upd_t           upd,
    output logic               grant,
    output logic [MUTEXES-1:0] tbl
);
    logic [MUTEXES-1:0] tbl_q;
    logic               grant_q;
    logic               idx_ok;
    logic               local_free;

    assign idx_ok     = (32'(idx) < MUTEXES);
    assign local_free = idx_ok && !tbl_q[idx];
    assign commit     = my_turn && req && !busy && idx_ok &&
                        ((op == OP_REL) || local_free);

    always_comb begin
        upd       = '0;
        upd.valid = commit;
        upd.set   = (op == OP_ACQ);
        upd.src   = TMR_FW'(ID);
        upd.idx   = TMR_FW'(idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q   <= '0;
            grant_q <= 1'b0;
        end else begin
            grant_q <= commit;
            if (commit) begin
                tbl_q[idx] <= (op == OP_ACQ);
            end else if (bcast.valid && bcast.src != TMR_FW'(ID)) begin
                for (int m = 0; m < MUTEXES; m++) begin
                    if (bcast.idx == TMR_FW'(m)) begin
                        tbl_q[m] <= bcast.set;
                    end
                end
            end
        end
    end

    assign tbl   = tbl_q;
    assign grant = grant_q;
endmodule

// File: rtl/token_mutex_ring.sv
module token_mutex_ring
    import tmr_pkg::*;
#(
    parameter int NODES       = 4,
    parameter int MUTEXES     = 8,
    parameter int PROP_CYCLES = 3,
    localparam int IDXW = tmr_idxw(MUTEXES),
    localparam int TW   = tmr_idxw(NODES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NODES-1:0]         req_i,
    input  logic [NODES-1:0]         rel_i,
    input  logic [NODES*IDXW-1:0]    idx_i,
    output logic [NODES-1:0]         grant_o,
    output logic                     busy_o,
    output logic [NODES*MUTEXES-1:0] table_o
);
    logic [TW-1:0]    tok_idx;
    logic [NODES-1:0] tok_1h;
    logic [NODES-1:0] commit;
    tmr_upd_t         node_upd [NODES];
    tmr_upd_t         pipe_in;
    tmr_upd_t         pipe_out;
    logic             busy;

    tmr_turn_counter #(.NODES(NODES)) u_turn (
        .clk     (clk),
        .rst     (rst),
        .turn    (tok_idx),
        .turn_1h (tok_1h)
    );

    genvar n;
    generate
        for (n = 0; n < NODES; n++) begin : g_node
            tmr_op_e op_n;
            assign op_n = rel_i[n] ? OP_REL : OP_ACQ;

            tmr_node #(.MUTEXES(MUTEXES), .ID(n)) u_node (
                .clk     (clk),
                .rst     (rst),
                .my_turn (tok_1h[n]),
                .busy    (busy),
                .req     (req_i[n]),
                .op      (op_n),
                .idx     (idx_i[n*IDXW +: IDXW]),
                .bcast   (pipe_out),
                .commit  (commit[n]),
                .upd     (node_upd[n]),
                .grant   (grant_o[n]),
                .tbl     (table_o[n*MUTEXES +: MUTEXES])
            );
        end
    endgenerate

    // The turn is unique, so at most one commit feeds the pipe per cycle.
    always_comb begin
        pipe_in = '0;
        for (int i = 0; i < NODES; i++) begin
            if (commit[i]) begin
                pipe_in = node_upd[i];
            end
        end
    end

    tmr_bcast_pipe #(.PROP_CYCLES(PROP_CYCLES)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .upd_in    (pipe_in),
        .upd_out   (pipe_out),
        .in_flight (busy)
    );

    assign busy_o = busy;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int NODES       = 4,
    parameter int MUTEXES     = 8,
    parameter int PROP_CYCLES = 3,
    parameter int TW          = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NODES-1:0]         grant_o,
    input logic                     busy_o,
    input logic [NODES*MUTEXES-1:0] table_o,
    input logic [TW-1:0]            tok_idx
);
    logic [15:0] run_q;
    logic        rows_equal;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (busy_o) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    always_comb begin
        rows_equal = 1'b1;
        for (int i = 1; i < NODES; i++) begin
            if (table_o[i*MUTEXES +: MUTEXES] != table_o[0 +: MUTEXES]) begin
                rows_equal = 1'b0;
            end
        end
    end

    // R6
    busy_len_max_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (run_q < 16'(PROP_CYCLES)));

    // R6
    busy_len_exact_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (run_q == 16'(PROP_CYCLES)));

    // R8
    grant_starts_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (|grant_o) |-> (busy_o && run_q == 16'd0));

    // R1
    grant_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (|grant_o) |-> (grant_o == (NODES'(1) << $past(tok_idx))));

    // R9
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    // R7
    tables_agree_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> rows_equal);
endmodule

bind token_mutex_ring tmr_checker #(
    .NODES(NODES), .MUTEXES(MUTEXES), .PROP_CYCLES(PROP_CYCLES), .TW(TW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .grant_o (grant_o),
    .busy_o  (busy_o),
    .table_o (table_o),
    .tok_idx (tok_idx)
);

// File: tb/test_token_mutex_ring.sv
module test_token_mutex_ring;
    localparam int N    = 4;
    localparam int M    = 8;
    localparam int P    = 3;
    localparam int IW   = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      req_i = '0;
    logic [N-1:0]      rel_i = '0;
    logic [N*IW-1:0]   idx_i = '0;
    logic [N-1:0]      grant_o;
    logic              busy_o;
    logic [N*M-1:0]    table_o;

    int checks = 0;
    int fails  = 0;
    int bt     = 0;   // expected turn holder, from R1

    always #2 clk = ~clk;

    token_mutex_ring #(.NODES(N), .MUTEXES(M), .PROP_CYCLES(P)) i_token_mutex_ring (
        .clk(clk), .rst(rst), .req_i(req_i), .rel_i(rel_i), .idx_i(idx_i),
        .grant_o(grant_o), .busy_o(busy_o), .table_o(table_o)
    );

    always @(posedge clk) begin
        if (rst) bt <= 0;
        else     bt <= (bt + 1) % N;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic drive(input int n, input bit rq, input bit rl, input int m);
        req_i[n] = rq;
        rel_i[n] = rl;
        idx_i[n*IW +: IW] = IW'(m);
    endtask

    function automatic bit tbit(input int n, input int m);
        return table_o[n*M + m];
    endfunction

    // Waits for grant_o[n]; returns 1 when seen and the holder at the commit edge.
    task automatic wait_grant(input int n, input int lim, output bit got, output int holder);
        got = 0;
        holder = -1;
        for (int c = 0; c < lim; c++) begin
            step();
            if (grant_o[n]) begin
                got = 1;
                holder = (bt + N - 1) % N;
                break;
            end
        end
    endtask

    // Called at the negedge of a grant; counts the busy run including it.
    task automatic count_busy(output int len);
        len = busy_o ? 1 : 0;
        step();
        check("R3 grant one cycle", int'(|grant_o), 0);
        while (busy_o && len < 50) begin
            len++;
            step();
        end
    endtask

    task automatic t_reset();
        check("R2 table clear", int'(|table_o), 0);
        check("R2 busy low", int'(busy_o), 0);
        check("R2 grant low", int'(|grant_o), 0);
    endtask

    task automatic t_acquire();
        bit got; int holder; int len;
        drive(1, 1'b1, 1'b0, 3);
        wait_grant(1, 2*N, got, holder);
        drive(1, 1'b0, 1'b0, 0);
        check("R3 acquire granted", int'(got), 1);
        check("R1 grant on own turn", holder, 1);
        check("R3 own bit set", int'(tbit(1, 3)), 1);
        check("R7 other copy not yet", int'(tbit(0, 3)), 0);
        count_busy(len);
        check("R6 busy length", len, P);
        for (int i = 0; i < N; i++) check("R7 copies updated", int'(tbit(i, 3)), 1);
    endtask

    task automatic t_contend();
        bit got; int holder; int len;
        drive(2, 1'b1, 1'b0, 3);
        wait_grant(2, 3*N, got, holder);
        check("R4 held mutex not granted", int'(got), 0);
        check("R4 copy unchanged", int'(tbit(2, 3)), 1);
        drive(1, 1'b1, 1'b1, 3);
        wait_grant(1, 2*N, got, holder);
        drive(1, 1'b0, 1'b0, 0);
        check("R5 release granted", int'(got), 1);
        check("R5 own bit clear", int'(tbit(1, 3)), 0);
        check("R8 pending not granted with release", int'(grant_o[2]), 0);
        count_busy(len);
        check("R6 busy length release", len, P);
        for (int i = 0; i < N; i++) check("R5 copies cleared", int'(tbit(i, 3)), 0);
        wait_grant(2, 2*N, got, holder);
        drive(2, 1'b0, 1'b0, 0);
        check("R4 pending granted after release", int'(got), 1);
        check("R1 retry on own turn", holder, 2);
        count_busy(len);
        for (int i = 0; i < N; i++) check("R4 new owner visible", int'(tbit(i, 3)), 1);
    endtask

    task automatic t_simul();
        int g0 = 0; int g3 = 0; int w; bit got; int holder; int len;
        drive(0, 1'b1, 1'b0, 5);
        drive(3, 1'b1, 1'b0, 5);
        for (int c = 0; c < 4*N + 4*P; c++) begin
            step();
            if (grant_o[0]) begin g0++; drive(0, 1'b0, 1'b0, 0); end
            if (grant_o[3]) begin g3++; drive(3, 1'b0, 1'b0, 0); end
        end
        drive(0, 1'b0, 1'b0, 0);
        drive(3, 1'b0, 1'b0, 0);
        check("R9 exactly one grant", g0 + g3, 1);
        for (int i = 0; i < N; i++) check("R9 mutex held", int'(tbit(i, 5)), 1);
        w = (g0 != 0) ? 0 : 3;
        drive(w, 1'b1, 1'b1, 5);
        wait_grant(w, 2*N, got, holder);
        drive(w, 1'b0, 1'b0, 0);
        check("R5 winner release", int'(got), 1);
        count_busy(len);
        for (int i = 0; i < N; i++) check("R5 mutex free", int'(tbit(i, 5)), 0);
    endtask

    task automatic t_pair();
        int c0 = -1; int c1 = -1; int gap;
        drive(0, 1'b1, 1'b0, 0);
        drive(1, 1'b1, 1'b0, 1);
        for (int c = 0; c < 4*N + 4*P; c++) begin
            step();
            if (grant_o[0]) begin c0 = c; drive(0, 1'b0, 1'b0, 0); end
            if (grant_o[1]) begin c1 = c; drive(1, 1'b0, 1'b0, 0); end
        end
        check("R3 node0 granted", int'(c0 >= 0), 1);
        check("R3 node1 granted", int'(c1 >= 0), 1);
        gap = (c0 > c1) ? c0 - c1 : c1 - c0;
        check("R8 grants spaced by busy", int'(gap >= P), 1);
        for (int i = 0; i < N; i++) begin
            check("R7 both bits", int'(tbit(i, 0) && tbit(i, 1)), 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        t_reset();
        rst = 1'b0;
        step();
        t_reset();
        t_acquire();
        repeat (2) step();
        t_contend();
        repeat (2) step();
        t_simul();
        repeat (3) step();
        t_pair();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule